// File: doc/BRIEF.md
# Variable-Latency Operation Packet Bus Slave

This block sits on the memory side of a synchronous, SRAM-like host bus whose latency changes from one request to the next. The host opens each request with an address phase: chip select and the address strobe both low, a 26-bit destination on the address bus, and the write-enable level saying which way the data will flow. A 4-beat burst of 16-bit words then crosses a shared bidirectional data bus. A stall output holds the host off until the back end can take or give the data.

A write request does not carry plain data. Its 64 data bits form one fixed-length operation packet: a 6-bit opcode, a 26-bit source address and a 32-bit immediate. The block puts the packet back together with the destination taken from the address phase. It presents the result to an execution unit over a valid/ready handshake.

A read request is passed to the back end as an address with a request flag. The 64-bit answer is returned to the host as four words. Dropping chip select in the middle of a request aborts it, and no packet is issued for it.

Top module: `opbus_slave`

## Requirements
- R1: After reset, `bus_wait`, `op_valid` and `rd_req` are 0 and the block does not drive `bus_dq`.
- R2: An address phase is a rising clock edge with `bus_ce_n`=0 and `bus_adv_n`=0 while no request is open. `bus_we_n`=0 at that edge opens a write (packet) request and `bus_we_n`=1 opens a read. The `bus_addr` value at that edge becomes the request's destination (`op_dest` or `rd_addr`).
- R3: Write beat k (k=0..3) carries packet bits [63-16k : 48-16k]. Within the packet, `op_code` is bits [63:58], `op_src` is bits [57:32] and `op_imm` is bits [31:0].
- R4: During a write data phase, `bus_wait` is 1 whenever `op_ready`=0 or a packet is still pending (`op_valid`=1). A beat is taken only at an edge where `bus_wait`=0. After the fourth beat, `op_valid` is 1 in the next cycle.
- R5: While `op_valid`=1 and `op_ready`=0, `op_valid` and all packet outputs hold. `op_valid` falls after an edge where `op_valid` and `op_ready` are both 1.
- R6: A read address phase raises `rd_req` in the next cycle with `rd_addr` equal to the destination. `rd_req` stays high until an edge where `rd_valid`=1.
- R7: During a read data phase, `bus_wait` is 1 until the back end has answered. The four words on `bus_dq` then follow one per cycle, word k being `rd_data` bits [63-16k : 48-16k].
- R8: `bus_dq` is driven only during a read data phase with `bus_ce_n`=0 and `bus_oe_n`=0. In every other case the host can drive it freely.
- R9: `bus_ce_n`=1 during a data phase aborts the request. No packet is issued, a pending `rd_req` is withdrawn, and a late `rd_valid` is ignored. The next request then works normally.
- R10: With `bus_ce_n`=1, a low `bus_adv_n` opens no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 26 | Destination address, sampled at the address phase |
| bus_adv_n | input | 1 | Address strobe, active low |
| bus_ce_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Output enable for read data, active low |
| bus_we_n | input | 1 | 0 = write/packet request, 1 = read request |
| bus_wait | output | 1 | 1 = data phase stalled |
| bus_dq | inout | 16 | Bidirectional burst data |
| op_valid | output | 1 | Decoded packet available |
| op_ready | input | 1 | Execution unit accepts the packet |
| op_code | output | 6 | Packet opcode |
| op_dest | output | 26 | Packet destination address |
| op_src | output | 26 | Packet source address |
| op_imm | output | 32 | Packet immediate |
| rd_req | output | 1 | Read request to the back end |
| rd_addr | output | 26 | Read address |
| rd_valid | input | 1 | Back end read answer valid |
| rd_data | input | 64 | Back end read answer |

## Verification
The hardest case to reach is a second write that arrives while the first packet is still held by a stalled execution unit. The second write's beats must be refused until the handshake completes. The bench holds `op_ready` low after one packet, opens another write, and drives a junk word while the stall output must stay high. It then releases the handshake and checks that only the later words make up the new packet. Aborts are reached by lifting chip select after two write beats, or before a read answer arrives and then sending a late answer. The request that follows must show a clean beat count and an empty read buffer.

// File: rtl/opbus_pkg.sv
package opbus_pkg;
  localparam int unsigned DEF_ADDR_W = 26;
  localparam int unsigned DEF_DQ_W   = 16;
  localparam int unsigned DEF_BEATS  = 4;
  localparam int unsigned DEF_OPC_W  = 6;
  localparam int unsigned DEF_SRC_W  = 26;
  localparam int unsigned DEF_IMM_W  = 32;

  typedef enum logic {PH_IDLE = 1'b0, PH_DATA = 1'b1} bus_phase_e;

  // lowest packet bit carried by a given beat (beat 0 is most significant)
  function automatic int unsigned lane_lsb(int unsigned beat, int unsigned beats,
                                           int unsigned width);
    return (beats - 1 - beat) * width;
  endfunction

  function automatic int unsigned cnt_width(int unsigned beats);
    return (beats > 1) ? $clog2(beats) : 1;
  endfunction
endpackage

// File: rtl/opbus_ctrl.sv
module opbus_ctrl
  import opbus_pkg::*;
#(
  parameter  int unsigned ADDR_W = DEF_ADDR_W,
  parameter  int unsigned BEATS  = DEF_BEATS,
  localparam int unsigned CNT_W  = cnt_width(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_ok,
  input  logic              rd_ok,
  output logic              in_data,
  output logic              is_rd,
  output logic [CNT_W-1:0]  beat_idx,
  output logic              addr_fire,
  output logic              beat_fire,
  output logic              last_fire,
  output logic              abort,
  output logic [ADDR_W-1:0] dest,
  output logic              bus_wait
);
  bus_phase_e        phase_q;
  logic              is_rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] dest_q;

  always_comb begin
    in_data   = (phase_q == PH_DATA);
    addr_fire = !in_data && !ce_n && !adv_n;
    bus_wait  = in_data && (is_rd_q ? !rd_ok : !wr_ok);
    beat_fire = in_data && !ce_n && !bus_wait;
    last_fire = beat_fire && (cnt_q == CNT_W'(BEATS - 1));
    abort     = in_data && ce_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      is_rd_q <= 1'b0;
      cnt_q   <= '0;
      dest_q  <= '0;
    end else if (addr_fire) begin
      phase_q <= PH_DATA;
      is_rd_q <= we_n;
      dest_q  <= addr;
      cnt_q   <= '0;
    end else if (abort) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (beat_fire) begin
      cnt_q <= last_fire ? '0 : cnt_q + 1'b1;
      if (last_fire) phase_q <= PH_IDLE;
    end
  end

  assign is_rd    = is_rd_q;
  assign beat_idx = cnt_q;
  assign dest     = dest_q;

  // R10: strobe with chip select high never opens a request
  assert_adv_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !in_data) |=> !in_data);
  // R9: chip select high in a data phase always ends it
  assert_abort_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !in_data);
endmodule

// File: rtl/opbus_wr_assemble.sv
module opbus_wr_assemble
  import opbus_pkg::*;
#(
  parameter  int unsigned DQ_W   = DEF_DQ_W,
  parameter  int unsigned BEATS  = DEF_BEATS,
  parameter  int unsigned ADDR_W = DEF_ADDR_W,
  localparam int unsigned PKT_W  = DQ_W * BEATS,
  localparam int unsigned CNT_W  = cnt_width(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lane_we,
  input  logic              last_we,
  input  logic [CNT_W-1:0]  beat_idx,
  input  logic [DQ_W-1:0]   dq_in,
  input  logic [ADDR_W-1:0] dest_in,
  input  logic              op_ready,
  output logic              op_valid,
  output logic [PKT_W-1:0]  pkt_word,
  output logic [ADDR_W-1:0] pkt_dest
);
  for (genvar b = 0; b < BEATS; b++) begin : g_lane
    logic [DQ_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                     lane_q <= '0;
      else if (lane_we && beat_idx == CNT_W'(b))      lane_q <= dq_in;
    end
    assign pkt_word[lane_lsb(b, BEATS, DQ_W) +: DQ_W] = lane_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      pkt_dest <= '0;
    end else begin
      if (last_we) begin
        op_valid <= 1'b1;
        pkt_dest <= dest_in;
      end else if (op_valid && op_ready) begin
        op_valid <= 1'b0;
      end
    end
  end

  // R5: a refused packet holds every field
  assert_pkt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(pkt_word) && $stable(pkt_dest)));
  // R5: an accepted packet leaves the slot
  assert_pkt_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> !op_valid);
endmodule

// File: rtl/opbus_rd_serializer.sv
module opbus_rd_serializer
  import opbus_pkg::*;
#(
  parameter  int unsigned DQ_W  = DEF_DQ_W,
  parameter  int unsigned BEATS = DEF_BEATS,
  localparam int unsigned PKT_W = DQ_W * BEATS,
  localparam int unsigned CNT_W = cnt_width(BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_set,
  input  logic             abort,
  input  logic             last_rd,
  input  logic [CNT_W-1:0] beat_idx,
  input  logic             in_data,
  input  logic             is_rd,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             rd_valid,
  input  logic [PKT_W-1:0] rd_data,
  output logic             rd_req,
  output logic             rd_full,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_oe
);
  logic [PKT_W-1:0] data_q;
  logic [DQ_W-1:0]  lane_sel [BEATS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_req  <= 1'b0;
      rd_full <= 1'b0;
      data_q  <= '0;
    end else begin
      if (abort)         rd_req <= 1'b0;
      else if (req_set)  rd_req <= 1'b1;
      else if (rd_valid) rd_req <= 1'b0;

      if (abort || last_rd) begin
        rd_full <= 1'b0;
      end else if (rd_req && rd_valid) begin
        rd_full <= 1'b1;
        data_q  <= rd_data;
      end
    end
  end

  for (genvar b = 0; b < BEATS; b++) begin : g_sel
    assign lane_sel[b] = data_q[lane_lsb(b, BEATS, DQ_W) +: DQ_W];
  end

  assign dq_out = lane_sel[beat_idx];
  assign dq_oe  = in_data && is_rd && !ce_n && !oe_n;

  // R6: request persists until answered or aborted
  assert_rdreq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid && !abort) |=> rd_req);
  // R8: never drive the bus during a write data phase
  assert_no_drive_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !is_rd) |-> !dq_oe);
endmodule

// File: rtl/opbus_slave.sv
module opbus_slave
  import opbus_pkg::*;
#(
  parameter  int unsigned ADDR_W = DEF_ADDR_W,
  parameter  int unsigned DQ_W   = DEF_DQ_W,
  parameter  int unsigned BEATS  = DEF_BEATS,
  parameter  int unsigned OPC_W  = DEF_OPC_W,
  parameter  int unsigned SRC_W  = DEF_SRC_W,
  parameter  int unsigned IMM_W  = DEF_IMM_W,
  localparam int unsigned PKT_W  = DQ_W * BEATS,
  localparam int unsigned CNT_W  = cnt_width(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_adv_n,
  input  logic              bus_ce_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  output logic              bus_wait,
  inout  wire  [DQ_W-1:0]   bus_dq,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [OPC_W-1:0]  op_code,
  output logic [ADDR_W-1:0] op_dest,
  output logic [SRC_W-1:0]  op_src,
  output logic [IMM_W-1:0]  op_imm,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [PKT_W-1:0]  rd_data
);
  logic             in_data, is_rd, addr_fire, beat_fire, last_fire, abort;
  logic [CNT_W-1:0] beat_idx;
  logic [ADDR_W-1:0] dest;
  logic             rd_full, dq_oe;
  logic [DQ_W-1:0]  dq_out;
  logic [PKT_W-1:0] pkt_word;
  logic             wr_ok, lane_we, last_we, last_rd, req_set;

  assign wr_ok   = !op_valid && op_ready;
  assign lane_we = beat_fire && !is_rd;
  assign last_we = last_fire && !is_rd;
  assign last_rd = last_fire && is_rd;
  assign req_set = addr_fire && bus_we_n;

  opbus_ctrl #(.ADDR_W(ADDR_W), .BEATS(BEATS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(bus_ce_n), .adv_n(bus_adv_n), .we_n(bus_we_n),
    .addr(bus_addr), .wr_ok(wr_ok), .rd_ok(rd_full), .in_data(in_data), .is_rd(is_rd),
    .beat_idx(beat_idx), .addr_fire(addr_fire), .beat_fire(beat_fire),
    .last_fire(last_fire), .abort(abort), .dest(dest), .bus_wait(bus_wait)
  );

  opbus_wr_assemble #(.DQ_W(DQ_W), .BEATS(BEATS), .ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .lane_we(lane_we), .last_we(last_we), .beat_idx(beat_idx),
    .dq_in(bus_dq), .dest_in(dest), .op_ready(op_ready), .op_valid(op_valid),
    .pkt_word(pkt_word), .pkt_dest(op_dest)
  );

  opbus_rd_serializer #(.DQ_W(DQ_W), .BEATS(BEATS)) u_rd (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .abort(abort), .last_rd(last_rd),
    .beat_idx(beat_idx), .in_data(in_data), .is_rd(is_rd), .ce_n(bus_ce_n),
    .oe_n(bus_oe_n), .rd_valid(rd_valid), .rd_data(rd_data), .rd_req(rd_req),
    .rd_full(rd_full), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  assign bus_dq  = dq_oe ? dq_out : 'z;
  assign rd_addr = dest;
  assign op_code = pkt_word[PKT_W-1 -: OPC_W];
  assign op_src  = pkt_word[IMM_W +: SRC_W];
  assign op_imm  = pkt_word[IMM_W-1:0];

  // R4: completing the fourth write beat presents a packet next cycle
  assert_last_beat_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_we |=> op_valid);
  // R4: a write beat is taken only with the slot free and the consumer ready
  assert_wr_beat_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lane_we |-> (!op_valid && op_ready));
  // R7: read words leave only after the back end answered
  assert_rd_beat_has_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && is_rd) |-> rd_full);
  // R9: an aborted request never raises a packet
  assert_abort_no_pkt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !$rose(op_valid));
endmodule

// File: tb/opbus_slave_tb.sv
module opbus_slave_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] bus_addr = '0;
  logic        bus_adv_n = 1'b1, bus_ce_n = 1'b1, bus_oe_n = 1'b1, bus_we_n = 1'b1;
  logic        bus_wait;
  wire  [15:0] bus_dq;
  logic [15:0] host_dq = '0;
  logic        host_oe = 1'b0;
  logic        op_valid, op_ready = 1'b0;
  logic [5:0]  op_code;
  logic [25:0] op_dest, op_src, rd_addr;
  logic [31:0] op_imm;
  logic        rd_req, rd_valid = 1'b0;
  logic [63:0] rd_data = '0;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;
  assign bus_dq = host_oe ? host_dq : 'z;

  opbus_slave u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_adv_n(bus_adv_n),
    .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_wait(bus_wait),
    .bus_dq(bus_dq), .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
    .op_dest(op_dest), .op_src(op_src), .op_imm(op_imm), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0]  t_op(int i);  return 6'((i * 5 + 1) % 64); endfunction
  function automatic logic [25:0] t_src(int i); return 26'h155_5555 ^ 26'(i * 26'h0_1111); endfunction
  function automatic logic [31:0] t_imm(int i); return 32'hA5A5_0000 + 32'(i) * 32'h1357; endfunction
  function automatic logic [25:0] t_dst(int i); return 26'h200_0000 + 26'(i) * 26'h1_0203; endfunction
  function automatic logic [63:0] t_pkt(int i); return {t_op(i), t_src(i), t_imm(i)}; endfunction
  function automatic logic [15:0] word_of(logic [63:0] v, int k);
    return 16'((v >> (16 * (3 - k))) & 64'hFFFF);
  endfunction

  task automatic addr_phase(input logic we, input logic [25:0] a);
    @(negedge clk);
    bus_ce_n = 1'b0; bus_adv_n = 1'b0; bus_we_n = we; bus_addr = a;
    @(negedge clk);
    bus_adv_n = 1'b1; bus_we_n = 1'b1;
  endtask

  task automatic send_beats(input logic [63:0] pkt);
    op_ready = 1'b1; host_oe = 1'b1;
    for (int k = 0; k < 4; k++) begin
      host_dq = word_of(pkt, k);
      #1;
      chk(bus_dq == host_dq, "R8 write beat bus free", 64'(bus_dq), 64'(host_dq));
      chk(!bus_wait, "R4 wait low when ready", 64'(bus_wait), 0);
      @(negedge clk);
    end
    op_ready = 1'b0; host_oe = 1'b0; bus_ce_n = 1'b1;
  endtask

  task automatic check_pkt(input int i);
    #1;
    chk(op_valid, "R4 valid after burst", 64'(op_valid), 1);
    chk(op_dest == t_dst(i), "R2 dest", 64'(op_dest), 64'(t_dst(i)));
    chk(op_code == t_op(i), "R3 opcode", 64'(op_code), 64'(t_op(i)));
    chk(op_src == t_src(i), "R3 source", 64'(op_src), 64'(t_src(i)));
    chk(op_imm == t_imm(i), "R3 immediate", 64'(op_imm), 64'(t_imm(i)));
  endtask

  task automatic hold_release(input int i, input int h);
    for (int c = 0; c < h; c++) begin
      @(negedge clk); #1;
      chk(op_valid && op_imm == t_imm(i) && op_src == t_src(i) && op_dest == t_dst(i),
          "R5 hold while not ready", 64'(op_imm), 64'(t_imm(i)));
    end
    op_ready = 1'b1;
    @(negedge clk);
    op_ready = 1'b0; #1;
    chk(!op_valid, "R5 release after handshake", 64'(op_valid), 0);
  endtask

  task automatic write_op(input int i, input int s, input int h);
    addr_phase(1'b0, t_dst(i));
    op_ready = 1'b0; host_oe = 1'b1; host_dq = 16'hDEAD;
    #1 chk(bus_wait, "R4 wait while not ready", 64'(bus_wait), 1);
    for (int c = 0; c < s; c++) begin
      @(negedge clk); #1;
      chk(bus_wait, "R4 stall persists", 64'(bus_wait), 1);
    end
    send_beats(t_pkt(i));
    check_pkt(i);
    hold_release(i, h);
  endtask

  task automatic read_op(input logic [25:0] a, input logic [63:0] d, input int lat);
    addr_phase(1'b1, a);
    bus_oe_n = 1'b0;
    #1;
    chk(rd_req, "R6 request raised", 64'(rd_req), 1);
    chk(rd_addr == a, "R6 read address", 64'(rd_addr), 64'(a));
    chk(bus_wait, "R7 wait before answer", 64'(bus_wait), 1);
    for (int c = 0; c < lat; c++) begin
      @(negedge clk); #1;
      chk(bus_wait && rd_req, "R7 wait and request held", {62'd0, bus_wait, rd_req}, 3);
    end
    rd_valid = 1'b1; rd_data = d;
    @(negedge clk);
    rd_valid = 1'b0; rd_data = '0;
    #1 chk(!rd_req, "R6 request dropped", 64'(rd_req), 0);
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(!bus_wait, "R7 no wait in beats", 64'(bus_wait), 0);
      chk(bus_dq == word_of(d, k), "R7 read word", 64'(bus_dq), 64'(word_of(d, k)));
      @(negedge clk);
    end
    bus_oe_n = 1'b1; bus_ce_n = 1'b1;
    #1 chk(!bus_wait, "R7 idle after burst", 64'(bus_wait), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    host_oe = 1'b1; host_dq = 16'h5A3C;
    #1;
    chk(!bus_wait && !op_valid && !rd_req, "R1 reset outputs",
        {61'd0, bus_wait, op_valid, rd_req}, 0);
    chk(bus_dq == 16'h5A3C, "R1 bus not driven", 64'(bus_dq), 64'h5A3C);
    host_oe = 1'b0;

    // R10: strobe with chip select high
    @(negedge clk);
    bus_adv_n = 1'b0; bus_we_n = 1'b1; bus_addr = 26'h123;
    @(negedge clk);
    bus_adv_n = 1'b1; #1;
    chk(!rd_req && !bus_wait, "R10 strobe ignored", {62'd0, rd_req, bus_wait}, 0);

    // sweep of writes with varied stall and hold
    for (int i = 0; i < 12; i++) write_op(i, i % 4, i % 3);

    // sweep of reads with varied latency
    for (int j = 0; j < 8; j++)
      read_op(26'h0AB_C000 + 26'(j * 37), 64'h0123_4567_89AB_CDEF ^ (64'(j) * 64'h1111_0101_1010_0001), j % 5);

    // R4/R5: second write while first packet is still refused
    addr_phase(1'b0, t_dst(20));
    send_beats(t_pkt(20));
    check_pkt(20);
    addr_phase(1'b0, t_dst(21));
    host_oe = 1'b1; host_dq = 16'hBEEF;
    #1;
    chk(bus_wait, "R4 wait while packet pending", 64'(bus_wait), 1);
    chk(op_valid && op_imm == t_imm(20), "R5 first packet held", 64'(op_imm), 64'(t_imm(20)));
    @(negedge clk); #1;
    chk(bus_wait, "R4 pending packet still blocks", 64'(bus_wait), 1);
    op_ready = 1'b1;
    @(negedge clk); #1;
    chk(!op_valid, "R5 first packet consumed", 64'(op_valid), 0);
    send_beats(t_pkt(21));
    check_pkt(21);
    hold_release(21, 1);

    // R9: write abort after two beats
    addr_phase(1'b0, t_dst(30));
    op_ready = 1'b1; host_oe = 1'b1;
    for (int k = 0; k < 2; k++) begin
      host_dq = word_of(t_pkt(30), k);
      @(negedge clk);
    end
    bus_ce_n = 1'b1; host_oe = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk(!op_valid && !bus_wait, "R9 no packet after write abort",
          {62'd0, op_valid, bus_wait}, 0);
    end
    op_ready = 1'b0;
    write_op(31, 1, 0);

    // R9: read abort with a late answer
    addr_phase(1'b1, 26'h3_3333);
    #1 chk(rd_req, "R9 request before abort", 64'(rd_req), 1);
    bus_ce_n = 1'b1;
    @(negedge clk); #1;
    chk(!rd_req, "R9 request withdrawn", 64'(rd_req), 0);
    rd_valid = 1'b1; rd_data = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    rd_valid = 1'b0; rd_data = '0;
    read_op(26'h3_4444, 64'hCAFE_0001_D00D_0002, 2);

    // R8: output enable high keeps the bus free during a read
    addr_phase(1'b1, 26'h5_5555);
    bus_oe_n = 1'b1;
    rd_valid = 1'b1; rd_data = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    rd_valid = 1'b0;
    host_oe = 1'b1; host_dq = 16'h0F0F;
    for (int k = 0; k < 4; k++) begin
      #1 chk(bus_dq == 16'h0F0F, "R8 not driven with oe high", 64'(bus_dq), 64'h0F0F);
      @(negedge clk);
    end
    host_oe = 1'b0; bus_ce_n = 1'b1;

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule